// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block decides which power state a chip should be in. It keeps one of five power states: standby, active, retention (suspend-to-RAM), low-power standby, and safe. Every cycle it looks at fourteen trigger sources. These are three fault flags, a watchdog error, a microcontroller error-signal fault, on and off requests, a wake pin, two sleep pins and four software command bits. From the triggers that are valid in the present state, it picks the one with the highest rank.

The winning trigger launches an encoded power sequence or function. The block announces the launch with a one-cycle start pulse and a sequence ID, holds a busy flag until an external engine returns a one-cycle done, and then moves to the trigger's destination state. The rail sequencing, self-test, bus CRC and NVM-update engines are outside the block; the block only sees them through this start/done handshake.

The three fault triggers are immediate: they can abort a running sequence. All other triggers wait for the running sequence to finish. Triggers marked reentrant may rerun from the state they lead to. Non-reentrant triggers whose destination is the present state are ignored.

Top module: `pwr_trig_fsm`

Named power states (output code): STANDBY (0), ACTIVE (1), RETAIN (2), LPSTBY (3), SAFE (4).

Named control states: IDLE, and RUN (busy).

Named transitions:
- IDLE to RUN on launch.
- RUN to RUN on preemption.
- RUN to IDLE on done, which also commits the power state.

## Requirements
- R1: After reset the state output is STANDBY (0), busy is 0, the start pulse is 0 and the sequence ID is 0.
- R2: A launch is seen one clock after the trigger is sampled. The start pulse is high for one cycle, busy rises and the sequence ID holds its code. On the clock edge that samples done while busy, the state takes the destination, busy falls and the ID returns to 0. The state changes at no other time.
- R3: Sequence ID codes are: 0 none, 1 severe-to-safe, 2 to-safe, 3 orderly-to-safe, 4 to-standby, 5 active-to-warm-reset, 6 runtime self-test, 7 bus CRC enable, 8 to-active, 9 to-retention, 10 NVM-update preparation.
- R4: The fault flags severe, power and orderly go from STANDBY, ACTIVE or RETAIN to SAFE with IDs 1, 2 and 3. Their rank is severe, then power, then orderly, above every other trigger.
- R5: While busy, a fault flag ranked strictly above the running trigger relaunches at once. A fault of equal or lower rank, or any other trigger, launches nothing until done.
- R6: The off request goes from ACTIVE or RETAIN to STANDBY with ID 4. In STANDBY it is ignored.
- R7: The watchdog error and the MCU error fault are valid only in ACTIVE. Each runs ID 5 and the state stays ACTIVE. Either one held high relaunches after each done.
- R8: The on request, a rising edge on the wake pin, or both sleep pins high each go from STANDBY or RETAIN to ACTIVE with ID 8. All three are ignored in ACTIVE.
- R9: In ACTIVE, sleep pin B low (with sleep pin A at either level) goes to RETAIN with ID 9. Sleep pin A low with sleep pin B high launches nothing.
- R10: A rising edge on command bit 0 goes from STANDBY or ACTIVE to LPSTBY with ID 4.
- R11: Rising edges on command bits 1, 2 and 3 are valid only in ACTIVE. They run IDs 6, 7 and 10 respectively and leave the state unchanged.
- R12: Wake and command edges are held pending while the block is busy or a higher trigger wins, and launch later. They clear on launch. A bit held high launches once. When idle, an edge that is not valid in the present state is dropped.
- R13: SAFE and LPSTBY are left only through reset; no trigger launches from them.
- R14: Non-fault triggers rank off, watchdog, MCU error, command 1, command 2, on, wake, both sleep high, sleep B low, command 0, command 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_severe_i | input | 1 | Severe fault, level |
| fault_pwr_i | input | 1 | MCU power fault, level |
| fault_orderly_i | input | 1 | Orderly shutdown fault, level |
| off_req_i | input | 1 | Off request, level |
| wdt_err_i | input | 1 | Watchdog error, level |
| mcu_err_i | input | 1 | MCU error-signal fault, level |
| on_req_i | input | 1 | On request, level |
| wake_i | input | 1 | Wake pin, rising edge |
| sleep_a_i | input | 1 | Sleep pin A, level |
| sleep_b_i | input | 1 | Sleep pin B, level |
| cmd_i | input | 4 | Software command bits, rising edge each |
| seq_done_i | input | 1 | One-cycle done from the sequence engine |
| pstate_o | output | 3 | Present power state code |
| seq_start_o | output | 1 | One-cycle sequence launch pulse |
| seq_id_o | output | 4 | Running sequence ID, 0 when idle |
| busy_o | output | 1 | Sequence in progress |

## Verification
A corrupt power state register shows up on the state output immediately. It also surfaces one cycle later as a missing or unexpected launch, because validity depends on that state. A wrong busy or running-rank register shows as a launch while busy, or a fault that fails to preempt, within one cycle of the trigger. A lost pending edge shows only after the next done, as a missing launch one cycle after busy falls.

// File: rtl/pwr_trig_pkg.sv
`timescale 1ns/1ps
package pwr_trig_pkg;

    localparam int TRIG_N = 14;
    localparam int IDX_W  = $clog2(TRIG_N);
    localparam int SEQ_W  = 4;
    localparam int ST_W   = 3;
    localparam int ST_N   = 5;
    localparam int CMD_W  = 4;
    localparam int EDGE_N = 5;

    typedef enum logic [ST_W-1:0] {
        PS_STANDBY = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_RETAIN  = 3'd2,
        PS_LPSTBY  = 3'd3,
        PS_SAFE    = 3'd4
    } pstate_e;

    typedef enum logic [SEQ_W-1:0] {
        SQ_NONE         = 4'd0,
        SQ_SAFE_SEVERE  = 4'd1,
        SQ_SAFE         = 4'd2,
        SQ_SAFE_ORDERLY = 4'd3,
        SQ_STANDBY      = 4'd4,
        SQ_WARM         = 4'd5,
        SQ_BIST         = 4'd6,
        SQ_CRC          = 4'd7,
        SQ_ACTIVE       = 4'd8,
        SQ_RETAIN       = 4'd9,
        SQ_NVM          = 4'd10
    } seq_e;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_e;

    // trigger indices in rank order, 0 is highest
    localparam int T_SEVERE  = 0;
    localparam int T_PWR     = 1;
    localparam int T_ORDERLY = 2;
    localparam int T_OFF     = 3;
    localparam int T_WDT     = 4;
    localparam int T_MCU     = 5;
    localparam int T_CMD1    = 6;
    localparam int T_CMD2    = 7;
    localparam int T_ON      = 8;
    localparam int T_WAKE    = 9;
    localparam int T_SLP_ON  = 10;
    localparam int T_SLP_RET = 11;
    localparam int T_CMD0    = 12;
    localparam int T_CMD3    = 13;

    // edge-captured sources, position g maps to trigger EDGE_MAP[g]
    localparam int EDGE_MAP [EDGE_N] = '{T_CMD1, T_CMD2, T_WAKE, T_CMD0, T_CMD3};

    localparam logic [ST_N-1:0] SRC_SAR = 5'b00111;
    localparam logic [ST_N-1:0] SRC_SA  = 5'b00011;
    localparam logic [ST_N-1:0] SRC_A   = 5'b00010;

    typedef struct packed {
        logic            imm;
        logic            reent;
        logic            in_place;
        pstate_e         dest;
        seq_e            seq;
        logic [ST_N-1:0] src;
    } trig_attr_t;

    function automatic trig_attr_t trig_attr(input int idx);
        trig_attr_t a;
        a.imm      = 1'b0;
        a.reent    = 1'b0;
        a.in_place = 1'b0;
        a.dest     = PS_STANDBY;
        a.seq      = SQ_NONE;
        a.src      = '0;
        case (idx)
            T_SEVERE:  begin a.imm = 1'b1; a.dest = PS_SAFE; a.seq = SQ_SAFE_SEVERE;  a.src = SRC_SAR; end
            T_PWR:     begin a.imm = 1'b1; a.dest = PS_SAFE; a.seq = SQ_SAFE;         a.src = SRC_SAR; end
            T_ORDERLY: begin a.imm = 1'b1; a.dest = PS_SAFE; a.seq = SQ_SAFE_ORDERLY; a.src = SRC_SAR; end
            T_OFF:     begin a.dest = PS_STANDBY; a.seq = SQ_STANDBY; a.src = SRC_SAR; end
            T_WDT:     begin a.reent = 1'b1; a.dest = PS_ACTIVE; a.seq = SQ_WARM; a.src = SRC_A; end
            T_MCU:     begin a.reent = 1'b1; a.dest = PS_ACTIVE; a.seq = SQ_WARM; a.src = SRC_A; end
            T_CMD1:    begin a.reent = 1'b1; a.in_place = 1'b1; a.seq = SQ_BIST; a.src = SRC_A; end
            T_CMD2:    begin a.reent = 1'b1; a.in_place = 1'b1; a.seq = SQ_CRC;  a.src = SRC_A; end
            T_ON:      begin a.dest = PS_ACTIVE; a.seq = SQ_ACTIVE; a.src = SRC_SAR; end
            T_WAKE:    begin a.dest = PS_ACTIVE; a.seq = SQ_ACTIVE; a.src = SRC_SAR; end
            T_SLP_ON:  begin a.dest = PS_ACTIVE; a.seq = SQ_ACTIVE; a.src = SRC_SAR; end
            T_SLP_RET: begin a.dest = PS_RETAIN; a.seq = SQ_RETAIN; a.src = SRC_A; end
            T_CMD0:    begin a.dest = PS_LPSTBY; a.seq = SQ_STANDBY; a.src = SRC_SA; end
            T_CMD3:    begin a.in_place = 1'b1; a.seq = SQ_NVM; a.src = SRC_A; end
            default:   begin a.src = '0; end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/pwr_trig_edge.sv
`timescale 1ns/1ps
module pwr_trig_edge #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] take_i,
    input  logic [W-1:0] drop_i,
    output logic [W-1:0] evt_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;

    // a fresh rising edge counts in the cycle it appears
    assign evt_o = pend_q | (lvl_i & ~prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lvl_i;
            pend_q <= evt_o & ~take_i & ~drop_i;
        end
    end

endmodule

// File: rtl/pwr_trig_arb.sv
`timescale 1ns/1ps
module pwr_trig_arb
    import pwr_trig_pkg::*;
(
    input  logic [TRIG_N-1:0] present_i,
    input  pstate_e           cur_i,
    input  logic              running_i,
    input  logic [IDX_W-1:0]  run_idx_i,
    output logic [TRIG_N-1:0] elig_o,
    output logic              win_vld_o,
    output logic [IDX_W-1:0]  win_idx_o
);

    logic [TRIG_N-1:0] cand;

    for (genvar g = 0; g < TRIG_N; g++) begin : g_trig
        localparam trig_attr_t A = trig_attr(g);
        logic in_src;
        logic same_dst;
        assign in_src   = |(A.src & (ST_N'(1) << cur_i));
        assign same_dst = !A.in_place && (A.dest == cur_i);
        assign elig_o[g] = present_i[g] && in_src && !(same_dst && !A.reent);
        // while running, only a strictly higher immediate trigger may cut in
        assign cand[g] = elig_o[g] &&
                         (!running_i || (A.imm && (IDX_W'(g) < run_idx_i)));
    end

    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        for (int i = TRIG_N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pwr_trig_dec.sv
`timescale 1ns/1ps
module pwr_trig_dec
    import pwr_trig_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  pstate_e          cur_i,
    output seq_e             seq_o,
    output pstate_e          dest_o
);

    trig_attr_t attr;

    always_comb begin
        attr   = trig_attr(int'(idx_i));
        seq_o  = attr.seq;
        dest_o = attr.in_place ? cur_i : attr.dest;
    end

endmodule

// File: rtl/pwr_trig_fsm.sv
`timescale 1ns/1ps
module pwr_trig_fsm
    import pwr_trig_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fault_severe_i,
    input  logic             fault_pwr_i,
    input  logic             fault_orderly_i,
    input  logic             off_req_i,
    input  logic             wdt_err_i,
    input  logic             mcu_err_i,
    input  logic             on_req_i,
    input  logic             wake_i,
    input  logic             sleep_a_i,
    input  logic             sleep_b_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             seq_done_i,
    output logic [ST_W-1:0]  pstate_o,
    output logic             seq_start_o,
    output logic [SEQ_W-1:0] seq_id_o,
    output logic             busy_o
);

    ctl_e              ctl_q, ctl_d;
    pstate_e           ps_q, ps_d;
    pstate_e           dst_q, dst_d;
    logic [IDX_W-1:0]  ridx_q, ridx_d;
    logic              start_q, start_d;
    seq_e              sid_q, sid_d;

    logic [EDGE_N-1:0] edge_lvl, edge_evt, edge_take, edge_drop;
    logic [TRIG_N-1:0] present, elig;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    seq_e              win_seq;
    pstate_e           win_dest;

    // edge-sensed sources, order follows EDGE_MAP
    assign edge_lvl = {cmd_i[3], cmd_i[0], wake_i, cmd_i[2], cmd_i[1]};

    pwr_trig_edge #(.W(EDGE_N)) i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (edge_lvl),
        .take_i (edge_take),
        .drop_i (edge_drop),
        .evt_o  (edge_evt)
    );

    assign present[T_SEVERE]  = fault_severe_i;
    assign present[T_PWR]     = fault_pwr_i;
    assign present[T_ORDERLY] = fault_orderly_i;
    assign present[T_OFF]     = off_req_i;
    assign present[T_WDT]     = wdt_err_i;
    assign present[T_MCU]     = mcu_err_i;
    assign present[T_ON]      = on_req_i;
    assign present[T_SLP_ON]  = sleep_a_i & sleep_b_i;
    assign present[T_SLP_RET] = ~sleep_b_i;

    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        assign present[EDGE_MAP[g]] = edge_evt[g];
        assign edge_take[g] = win_vld && (win_idx == IDX_W'(EDGE_MAP[g]));
        assign edge_drop[g] = (ctl_q == CTL_IDLE) && !elig[EDGE_MAP[g]];
    end

    pwr_trig_arb i_arb (
        .present_i (present),
        .cur_i     (ps_q),
        .running_i (ctl_q == CTL_RUN),
        .run_idx_i (ridx_q),
        .elig_o    (elig),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx)
    );

    pwr_trig_dec i_dec (
        .idx_i  (win_idx),
        .cur_i  (ps_q),
        .seq_o  (win_seq),
        .dest_o (win_dest)
    );

    // next-state decision
    always_comb begin
        ctl_d   = ctl_q;
        ps_d    = ps_q;
        dst_d   = dst_q;
        ridx_d  = ridx_q;
        start_d = 1'b0;
        sid_d   = sid_q;
        unique case (ctl_q)
            CTL_IDLE: begin
                if (win_vld) begin
                    ctl_d   = CTL_RUN;
                    dst_d   = win_dest;
                    ridx_d  = win_idx;
                    start_d = 1'b1;
                    sid_d   = win_seq;
                end
            end
            CTL_RUN: begin
                if (win_vld) begin
                    dst_d   = win_dest;
                    ridx_d  = win_idx;
                    start_d = 1'b1;
                    sid_d   = win_seq;
                end else if (seq_done_i) begin
                    ctl_d  = CTL_IDLE;
                    ps_d   = dst_q;
                    ridx_d = '0;
                    sid_d  = SQ_NONE;
                end
            end
            default: ctl_d = CTL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q  <= CTL_IDLE;
            ps_q   <= PS_STANDBY;
            dst_q  <= PS_STANDBY;
            ridx_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            ps_q   <= ps_d;
            dst_q  <= dst_d;
            ridx_q <= ridx_d;
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_q <= 1'b0;
            sid_q   <= SQ_NONE;
        end else begin
            start_q <= start_d;
            sid_q   <= sid_d;
        end
    end

    assign pstate_o    = ps_q;
    assign seq_start_o = start_q;
    assign seq_id_o    = sid_q;
    assign busy_o      = (ctl_q == CTL_RUN);

endmodule

// File: rtl/pwr_trig_chk.sv
`timescale 1ns/1ps
module pwr_trig_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       fault_severe_i,
    input logic       fault_pwr_i,
    input logic       fault_orderly_i,
    input logic       seq_done_i,
    input logic [2:0] pstate_o,
    input logic       seq_start_o,
    input logic [3:0] seq_id_o,
    input logic       busy_o
);

    logic src_ok;
    assign src_ok = (pstate_o == 3'd0) || (pstate_o == 3'd1) || (pstate_o == 3'd2);

    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_start_o |-> (busy_o && (seq_id_o != 4'd0)));

    p_idle_noid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (seq_id_o == 4'd0));

    p_state_on_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pstate_o) |-> ($past(busy_o) && $past(seq_done_i)));

    p_severe_now_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_severe_i && src_ok && !(busy_o && (seq_id_o == 4'd1)))
        |=> (seq_start_o && (seq_id_o == 4'd1)));

    p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !seq_done_i && !fault_severe_i && !fault_pwr_i && !fault_orderly_i)
        |=> (busy_o && !seq_start_o));

    p_safe_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pstate_o == 3'd4) |=> ((pstate_o == 3'd4) && !seq_start_o));

    p_lpstby_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pstate_o == 3'd3) |=> ((pstate_o == 3'd3) && !seq_start_o));

endmodule

bind pwr_trig_fsm pwr_trig_chk i_chk (.*);

// File: tb/test_pwr_trig_fsm.sv
`timescale 1ns/1ps
module test_pwr_trig_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       f_sev = 0, f_pwr = 0, f_ord = 0, off_req = 0, wdt = 0, mcu = 0;
    logic       on_req = 0, wake = 0, slp_a = 0, slp_b = 1, done = 0;
    logic [3:0] cmd = '0;
    logic [2:0] pstate;
    logic       start, busy;
    logic [3:0] sid;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pwr_trig_fsm i_pwr_trig_fsm (
        .clk_i(clk), .rst_ni(rst_n),
        .fault_severe_i(f_sev), .fault_pwr_i(f_pwr), .fault_orderly_i(f_ord),
        .off_req_i(off_req), .wdt_err_i(wdt), .mcu_err_i(mcu),
        .on_req_i(on_req), .wake_i(wake), .sleep_a_i(slp_a), .sleep_b_i(slp_b),
        .cmd_i(cmd), .seq_done_i(done),
        .pstate_o(pstate), .seq_start_o(start), .seq_id_o(sid), .busy_o(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input int t, input logic v);
        case (t)
            0:  f_sev = v;
            1:  f_pwr = v;
            2:  f_ord = v;
            3:  off_req = v;
            4:  wdt = v;
            5:  mcu = v;
            6:  cmd[1] = v;
            7:  cmd[2] = v;
            8:  on_req = v;
            9:  wake = v;
            10: slp_a = v;
            11: slp_b = ~v;
            12: cmd[0] = v;
            13: cmd[3] = v;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        f_sev = 0; f_pwr = 0; f_ord = 0; off_req = 0; wdt = 0; mcu = 0;
        on_req = 0; wake = 0; slp_a = 0; slp_b = 1; done = 0; cmd = '0;
        rst_n = 0;
        step();
        step();
        rst_n = 1;
    endtask

    task automatic finish_seq();
        done = 1;
        step();
        done = 0;
    endtask

    task automatic pulse(input int t);
        drive(t, 1);
        step();
        drive(t, 0);
    endtask

    task automatic go_to(input int s);
        case (s)
            1: begin pulse(8); finish_seq(); end
            2: begin pulse(8); finish_seq(); pulse(11); finish_seq(); end
            3: begin pulse(8); finish_seq(); pulse(12); finish_seq(); end
            4: begin pulse(0); finish_seq(); end
            default: ;
        endcase
    endtask

    // expected launch per trigger and start state, from the requirements
    task automatic expect_of(input int t, input int s, output bit ok,
                             output int id, output int dst, output string req);
        bit sa  = (s == 0) || (s == 1) || (s == 2);
        bit act = (s == 1);
        ok = 0; id = 0; dst = s; req = "R3";
        case (t)
            0, 1, 2: begin ok = sa; id = t + 1; dst = 4; req = "R4"; end
            3:       begin ok = (s == 1) || (s == 2); id = 4; dst = 0; req = "R6"; end
            4, 5:    begin ok = act; id = 5; dst = 1; req = "R7"; end
            6:       begin ok = act; id = 6; dst = 1; req = "R11"; end
            7:       begin ok = act; id = 7; dst = 1; req = "R11"; end
            8, 9, 10: begin ok = (s == 0) || (s == 2); id = 8; dst = 1; req = "R8"; end
            11:      begin ok = act; id = 9; dst = 2; req = "R9"; end
            12:      begin ok = (s == 0) || (s == 1); id = 4; dst = 3; req = "R10"; end
            13:      begin ok = act; id = 10; dst = 1; req = "R11"; end
            default: ;
        endcase
        if (!ok) dst = s;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit    ok;
        int    id;
        int    dst;
        string req;

        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 state", pstate, 0);
        chk("R1 busy", busy, 0);
        chk("R1 start", start, 0);
        chk("R1 id", sid, 0);

        // sweep every trigger from each live state (R2, R3 and per-trigger reqs)
        for (int s = 0; s < 3; s++) begin
            for (int t = 0; t < 14; t++) begin
                do_reset();
                go_to(s);
                chk("R2 setup state", pstate, s);
                expect_of(t, s, ok, id, dst, req);
                drive(t, 1);
                step();
                chk({req, " start"}, start, ok);
                chk({req, " id"}, sid, ok ? id : 0);
                drive(t, 0);
                if (ok) begin
                    finish_seq();
                    chk({req, " R2 dest"}, pstate, dst);
                    chk("R2 busy after done", busy, 0);
                end else begin
                    step();
                    chk({req, " ignored state"}, pstate, s);
                    chk({req, " ignored busy"}, busy, 0);
                end
            end
        end

        // R13 terminal states
        for (int s = 3; s < 5; s++) begin
            for (int t = 0; t < 14; t++) begin
                do_reset();
                go_to(s);
                drive(t, 1);
                step();
                chk("R13 start", start, 0);
                step();
                chk("R13 busy", busy, 0);
                chk("R13 state", pstate, s);
                drive(t, 0);
            end
        end

        // R4 fault ranking
        do_reset();
        f_sev = 1; f_pwr = 1; f_ord = 1;
        step();
        chk("R4 all faults id", sid, 1);
        f_sev = 0; f_pwr = 0; f_ord = 0;
        do_reset();
        f_pwr = 1; f_ord = 1;
        step();
        chk("R4 power over orderly", sid, 2);
        f_pwr = 0; f_ord = 0;

        // R14 non-fault ranking
        do_reset();
        go_to(1);
        off_req = 1; wdt = 1; cmd[3] = 1;
        step();
        chk("R14 off wins id", sid, 4);
        off_req = 0; wdt = 0; cmd[3] = 0;
        finish_seq();
        chk("R14 state", pstate, 0);
        step();
        chk("R14 lower edge dropped", start, 0);
        do_reset();
        go_to(1);
        mcu = 1; cmd[1] = 1;
        step();
        chk("R14 mcu over cmd1", sid, 5);
        mcu = 0; cmd[1] = 0;
        finish_seq();
        step();
        chk("R14 cmd1 pending launch", sid, 6);
        finish_seq();

        // R5 preemption
        do_reset();
        go_to(1);
        off_req = 1;
        step();
        chk("R5 off start", sid, 4);
        off_req = 0; wdt = 1;
        step();
        chk("R5 non-immediate held", start, 0);
        wdt = 0; f_ord = 1;
        step();
        chk("R5 orderly preempts start", start, 1);
        chk("R5 orderly preempts id", sid, 3);
        step();
        chk("R5 equal rank no restart", start, 0);
        f_sev = 1;
        step();
        chk("R5 severe preempts id", sid, 1);
        f_pwr = 1;
        step();
        chk("R5 lower fault held", start, 0);
        chk("R5 id kept", sid, 1);
        f_sev = 0; f_pwr = 0; f_ord = 0;
        finish_seq();
        chk("R5 final state", pstate, 4);

        // R7 reentrant level relaunch
        do_reset();
        go_to(1);
        wdt = 1;
        step();
        chk("R7 first run", sid, 5);
        finish_seq();
        chk("R7 stays active", pstate, 1);
        step();
        chk("R7 rerun start", start, 1);
        chk("R7 rerun id", sid, 5);
        wdt = 0;
        finish_seq();

        // R9 sleep patterns
        do_reset();
        go_to(1);
        slp_a = 0; slp_b = 1;
        step(); step(); step();
        chk("R9 no-op busy", busy, 0);
        chk("R9 no-op state", pstate, 1);
        slp_a = 1; slp_b = 0;
        step();
        chk("R9 A high B low id", sid, 9);
        finish_seq();
        chk("R9 retain", pstate, 2);
        slp_a = 0; slp_b = 1;

        // R12 pending, clear and drop
        do_reset();
        go_to(1);
        wdt = 1;
        step();
        wdt = 0;
        pulse(6);
        chk("R12 edge held while busy", start, 0);
        finish_seq();
        chk("R12 idle after done", start, 0);
        step();
        chk("R12 pending launch start", start, 1);
        chk("R12 pending launch id", sid, 6);
        finish_seq();
        step(); step();
        chk("R12 cleared after launch", busy, 0);

        do_reset();
        pulse(7);
        chk("R12 invalid edge no start", start, 0);
        go_to(1);
        step(); step();
        chk("R12 invalid edge dropped", busy, 0);

        do_reset();
        go_to(1);
        cmd[3] = 1;
        step();
        chk("R12 cmd3 launch", sid, 10);
        finish_seq();
        step(); step();
        chk("R12 held bit once", busy, 0);
        cmd[3] = 0;

        summary();
        $finish;
    end

endmodule